// File: doc/BRIEF.md
# SPI Byte Master Engine

The engine moves one byte over a four-wire serial link as the bus master. A host presents a byte on `tx_byte`, picks the clock idle level, the clock phase, the bit order and a half-period divider, and pulses `start`. The engine pulls `ss_n` low and toggles `sck` sixteen times. It shifts the byte out on `mosi` and gathers the byte arriving on `miso`. It then releases the link and pulses `done`.

Each `sck` edge has a fixed role. The first edge after `ss_n` falls is the leading edge. It is rising when `cpol` is 0 and falling when `cpol` is 1. When `cpha` is 0, leading edges sample and trailing edges change the data. When `cpha` is 1, the roles swap. As a result, data always changes half an `sck` period before it is captured. The mode number is `{cpol,cpha}`, so mode 0 is 0,0 and mode 3 is 1,1.

The mode, bit order, divider and byte are captured when `start` is accepted. After that point they may change freely without affecting the running transfer.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `busy`, `done` and `rx_byte` are 0, `ss_n` is 1, and while idle `sck` equals `cpol`.
- R2: A `start` seen on a clock edge while idle makes `busy` 1 and `ss_n` 0 from that edge on, and latches `tx_byte`, `cpol`, `cpha`, `lsb_first` and `div`.
- R3: A transfer makes exactly 16 `sck` edges. The first is the leading edge, which moves away from `cpol`. Edge k (0..15) falls (k+1)·(D+1) clocks after the accepting edge, where D is the effective divider.
- R4: With `cpha`=0, the first data bit is on `mosi` as soon as `ss_n` is low. `miso` is captured on leading edges and `mosi` changes on trailing edges.
- R5: With `cpha`=1, `mosi` changes on leading edges and `miso` is captured on trailing edges.
- R6: `lsb_first`=0 sends bit 7 first and places the first received bit in `rx_byte[7]`. `lsb_first`=1 sends bit 0 first and places the first received bit in `rx_byte[0]`.
- R7: 17·(D+1) clocks after the accepting edge, `busy` drops, `ss_n` returns to 1 and `sck` sits at the latched idle level. At the same time `done` is 1 for exactly one cycle and `rx_byte` holds the received byte until the next start.
- R8: A `start` arriving while `busy` is 1 is ignored: the running byte, its timing and its result are unchanged.
- R9: Changes of `cpol`, `cpha`, `lsb_first`, `div` or `tx_byte` during a transfer do not affect it.
- R10: A `div` value of 0 is treated as 1, so the shortest half-period is 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| tx_byte | input | 8 | Byte to send |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| div | input | DIV_W | Half-period divider; half-period is div+1 clocks |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rx_byte | output | 8 | Received byte |

## Verification
The accepting clock edge is the reference point for every timing check, and D is the effective divider. `busy`, `ss_n` and, in phase 0, the first `mosi` bit are due one edge after `start` is sampled. Edge k of `sck` is due (k+1)·(D+1) clocks after the accepting edge. `done`, the release of `ss_n` and the final `rx_byte` are due 17·(D+1) clocks after it. The bench drives inputs and reads outputs on falling clock edges, numbers those falling edges from the accepting edge, and compares each change against the index the formula predicts. A behavioural slave works from `sck` alone, so any misplaced sample or setup edge shows up in the exchanged bytes.

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             ss_n,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte
);
  localparam int EDGES = 16;
  localparam int EW    = $clog2(EDGES + 1);

  logic             sck_q, pol_q, pha_q, ord_q;
  logic [DIV_W-1:0] div_q, cnt;
  logic [EW-1:0]    edge_n;
  logic [7:0]       tx_sr, rx_sr;
  logic [DIV_W-1:0] div_eff;
  logic             tick, is_sample, shift_tx, last;

  assign div_eff   = (div == '0) ? DIV_W'(1) : div;
  assign tick      = busy && (cnt == '0);
  assign last      = (edge_n == EW'(EDGES));
  assign is_sample = (edge_n[0] == pha_q);
  assign shift_tx  = !is_sample && !(pha_q && edge_n == '0);

  assign sck     = busy ? sck_q : cpol;
  assign ss_n    = !busy;
  assign mosi    = ord_q ? tx_sr[0] : tx_sr[7];
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      sck_q  <= 1'b0;
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      ord_q  <= 1'b0;
      div_q  <= '0;
      cnt    <= '0;
      edge_n <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          pol_q  <= cpol;
          pha_q  <= cpha;
          ord_q  <= lsb_first;
          div_q  <= div_eff;
          cnt    <= div_eff;
          edge_n <= '0;
          tx_sr  <= tx_byte;
          rx_sr  <= '0;
          sck_q  <= cpol;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt    <= div_q;
        edge_n <= edge_n + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          sck_q <= ~sck_q;
          if (is_sample)
            rx_sr <= ord_q ? {miso, rx_sr[7:1]} : {rx_sr[6:0], miso};
          if (shift_tx)
            tx_sr <= ord_q ? {1'b0, tx_sr[7:1]} : {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  assert_sck_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck_q));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && sck_q == pol_q));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(pol_q) && $stable(pha_q) && $stable(ord_q) && $stable(div_q)));

  assert_div_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_q != '0));
endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [7:0] div = 8'd1;
  logic miso;
  logic sck, mosi, ss_n, busy, done;
  logic [7:0] rx_byte;

  int vectors = 0;
  int miscompares = 0;

  bit s_cpol, s_cpha, s_lsb;
  logic [7:0] s_byte = 8'h00;
  logic [7:0] s_rx;
  int s_i, s_n;

  always #2.5 clk = ~clk;

  spi_byte_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .div(div),
    .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n), .busy(busy),
    .done(done), .rx_byte(rx_byte)
  );

  assign miso = (s_i >= 0 && s_i < 8) ? s_byte[s_lsb ? s_i : 7 - s_i] : 1'b0;

  always @(negedge ss_n) begin
    s_i  = s_cpha ? -1 : 0;
    s_n  = 0;
    s_rx = 8'h00;
  end

  always @(sck) begin
    if (!ss_n) begin
      if ((sck != s_cpol) == !s_cpha) begin
        if (s_n < 8) s_rx[s_lsb ? s_n : 7 - s_n] = mosi;
        s_n++;
      end else begin
        s_i++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ss_n", ss_n, 1);
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 sck idle low", sck, 0);
    cpol = 1'b1;
    @(negedge clk);
    chk("R1 sck idle high", sck, 1);
    cpol = 1'b0;
  endtask

  task automatic run_xfer(input bit cp, input bit ph, input bit lsb, input int d,
                          input logic [7:0] tx, input logic [7:0] sb, input bit poke,
                          input string tag);
    int de, idx, edges, bad, lim;
    logic prev;
    de = (d == 0) ? 1 : d;
    s_cpol = cp; s_cpha = ph; s_lsb = lsb; s_byte = sb;
    @(negedge clk);
    cpol = cp; cpha = ph; lsb_first = lsb; div = 8'(d); tx_byte = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 1;
    chk({tag, " R2 busy"}, busy, 1);
    chk({tag, " R2 ss_n"}, ss_n, 0);
    if (!ph) chk({tag, " R4 first bit"}, mosi, lsb ? tx[0] : tx[7]);
    prev = sck; edges = 0; bad = 0;
    lim = 17 * (de + 1) + 50;
    while (!done && idx < lim) begin
      @(negedge clk);
      idx++;
      if (poke && idx == 3) begin
        start = 1'b1; tx_byte = ~tx; cpol = ~cp; cpha = ~ph; lsb_first = ~lsb; div = 8'(d + 3);
      end
      if (poke && idx == 5) begin
        start = 1'b0; cpol = cp; cpha = ph; lsb_first = lsb; div = 8'(d);
      end
      if (sck != prev) begin
        edges++;
        if (idx != edges * (de + 1) + 1) bad++;
        if (edges == 1) chk({tag, " R3 leading direction"}, sck, !cp);
        prev = sck;
      end
    end
    chk({tag, " R3 edge count"}, edges, 16);
    chk({tag, " R3 edge timing errors"}, bad, 0);
    chk({tag, " R7 done index"}, idx, 17 * (de + 1) + 1);
    chk({tag, " R7 ss_n released"}, ss_n, 1);
    chk({tag, " R7 busy low"}, busy, 0);
    chk({tag, " R7 sck idle"}, sck, cp);
    chk({tag, ph ? " R5 R6 rx_byte" : " R4 R6 rx_byte"}, rx_byte, sb);
    chk({tag, ph ? " R5 R6 slave got" : " R4 R6 slave got"}, s_rx, tx);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, done, 0);
    chk({tag, " R7 rx held"}, rx_byte, sb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_xfer(0, 0, 0, 1, 8'hA5, 8'h3C, 0, "mode0 msb");
    run_xfer(0, 1, 0, 2, 8'h81, 8'hE7, 0, "mode1 msb");
    run_xfer(1, 0, 1, 3, 8'h12, 8'hC4, 0, "mode2 lsb");
    run_xfer(1, 1, 1, 1, 8'hF0, 8'h0B, 0, "mode3 lsb");
    run_xfer(0, 0, 1, 4, 8'h01, 8'h80, 0, "mode0 lsb");
    run_xfer(1, 1, 0, 2, 8'h80, 8'h01, 0, "mode3 msb");
    run_xfer(0, 1, 1, 2, 8'h6D, 8'h92, 1, "R8 R9 busy poke");
    run_xfer(1, 0, 0, 3, 8'hC3, 8'h5A, 1, "R8 R9 busy poke2");
    run_xfer(0, 0, 0, 0, 8'h99, 8'h66, 0, "R10 div0");
    run_xfer(1, 1, 1, 0, 8'h2E, 8'hB1, 0, "R10 div0 mode3");
    summary();
  end
endmodule